// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sits inside a memory controller and decides in which clock cycle each beat of an access to a chip-select area completes. An access begins with a one-cycle address strobe. In that cycle the block takes a snapshot of the area's timing fields: wait enable, first-beat wait count, later-beat wait count, zero-wait-burst flag, the burst indication and the burst length. From then on it produces a single-cycle beat-completion pulse for every beat, and a transfer-completion pulse together with the final beat.

With wait enable low, an external active-low ready line alone ends each beat. It is honoured in every cycle, including the strobe cycle itself, which gives a zero-wait beat. With wait enable high, an internal counter inserts a programmed number of wait cycles. The first beat and the later beats of a burst take separate counts. A zero-wait-burst option lets the later beats complete back to back. Address decoding, data paths and the memory device belong to other blocks.

Top module: `wait_state_gen`

## Requirements
- R1: With wait enable low, a beat completes (beat_done_o high for that cycle) in exactly the cycles where rdy_n_i is 0. A 0 in the strobe cycle completes the first beat in that same cycle. A 0 k cycles after a beat starts gives k waits.
- R2: With wait enable high, the first beat completes first_wait_i + 1 cycles after the strobe cycle. This gives 1 to 8 waits for the 3-bit field.
- R3: With wait enable high and zero_wait_burst_i low, each later burst beat completes later_wait_i + 2 cycles after the previous beat's completion. That is later_wait_i + 1 waits, so a field value of 0 gives one wait.
- R4: With wait enable high and zero_wait_burst_i high, each later burst beat completes in the cycle right after the previous one. With wait enable low, zero_wait_burst_i has no effect.
- R5: With wait enable high, rdy_n_i has no effect on any completion.
- R6: All timing fields and the burst inputs are taken in the strobe cycle. Changing them later in the transfer does not alter its timing.
- R7: burst_i = 0 gives a single beat. burst_i = 1 gives burst_len_i + 1 beats. beat_idx_o reads 0 for the first beat and rises by one per beat. xfer_done_o is high only with the final beat_done_o.
- R8: A strobe that arrives while a transfer is in progress (busy_o high) is ignored.
- R9: After reset the block is idle, with busy_o, beat_done_o and xfer_done_o low. While idle and with no strobe, rdy_n_i produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Address strobe, starts a transfer when idle |
| burst_i | input | 1 | Transfer is a burst |
| burst_len_i | input | LEN_W | Burst beats minus one |
| rdy_n_i | input | 1 | External active-low ready |
| wait_en_i | input | 1 | 1: internal wait counting, 0: external ready |
| first_wait_i | input | CNT_W | First-beat wait count minus one |
| later_wait_i | input | CNT_W | Later-beat wait count minus one |
| zero_wait_burst_i | input | 1 | Later burst beats take no waits |
| beat_done_o | output | 1 | Current beat completes this cycle |
| xfer_done_o | output | 1 | Final beat completes this cycle |
| beat_idx_o | output | LEN_W | Index of the current beat |
| busy_o | output | 1 | Transfer in progress after the strobe cycle |

## Verification
The start of a transfer and the completion of its first beat can fall in the same cycle. In external-ready mode with ready already low at the strobe, the same cycle can also be the end of the whole transfer. The bench provokes this with zero-wait external beats, both on a single access and at the head of a burst. It judges the result by requiring beat_done_o, beat_idx_o = 0 and the correct xfer_done_o value in the strobe cycle itself, and then the next beat in the very next cycle. Throughout every transfer, the strobe, ready and configuration inputs are scrambled, so that ignored stimulus would appear as stray or misplaced completion pulses.

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
  parameter int CNT_W = 3,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             burst_i,
  input  logic [LEN_W-1:0] burst_len_i,
  input  logic             rdy_n_i,
  input  logic             wait_en_i,
  input  logic [CNT_W-1:0] first_wait_i,
  input  logic [CNT_W-1:0] later_wait_i,
  input  logic             zero_wait_burst_i,
  output logic             beat_done_o,
  output logic             xfer_done_o,
  output logic [LEN_W-1:0] beat_idx_o,
  output logic             busy_o
);

  localparam int CW = CNT_W + 1;

  logic             busy_q, wen_q, zw_q;
  logic [CNT_W-1:0] later_q;
  logic [CW-1:0]    cnt_q;
  logic [LEN_W-1:0] left_q, idx_q;

  logic             start;
  logic             wen_eff, zw_eff, last;
  logic [CNT_W-1:0] later_eff;
  logic [LEN_W-1:0] left_eff;
  logic [CW-1:0]    reload;

  assign start     = strobe_i && !busy_q;
  assign wen_eff   = start ? wait_en_i : wen_q;
  assign zw_eff    = start ? (zero_wait_burst_i && wait_en_i) : zw_q;
  assign later_eff = start ? later_wait_i : later_q;
  assign left_eff  = start ? (burst_i ? burst_len_i : '0) : left_q;
  assign last      = (left_eff == '0);
  assign reload    = zw_eff ? '0 : ({1'b0, later_eff} + 1'b1);

  assign beat_done_o = (start && !wait_en_i && !rdy_n_i)
                     || (busy_q && (wen_q ? (cnt_q == '0) : !rdy_n_i));
  assign xfer_done_o = beat_done_o && last;
  assign beat_idx_o  = start ? '0 : idx_q;
  assign busy_o      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wen_q   <= 1'b0;
      zw_q    <= 1'b0;
      later_q <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      idx_q   <= '0;
    end else begin
      if (start) begin
        wen_q   <= wait_en_i;
        zw_q    <= zero_wait_burst_i && wait_en_i;
        later_q <= later_wait_i;
        busy_q  <= 1'b1;
        left_q  <= left_eff;
        idx_q   <= '0;
        cnt_q   <= {1'b0, first_wait_i};
      end else if (busy_q && wen_q && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (beat_done_o) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          busy_q <= 1'b1;
          left_q <= left_eff - 1'b1;
          idx_q  <= beat_idx_o + 1'b1;
          cnt_q  <= reload;
        end
      end
    end
  end

  p_internal_min_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wait_en_i) |-> !beat_done_o);

  p_zero_wait_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done_o && !xfer_done_o && wen_eff && zw_eff) |=> beat_done_o);

  p_later_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done_o && !xfer_done_o && wen_eff && !zw_eff) |=> !beat_done_o);

  p_ext_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wen_q && !rdy_n_i) |-> beat_done_o);

  p_xfer_with_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> beat_done_o);

  p_xfer_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !busy_o);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !strobe_i) |-> !beat_done_o);

endmodule

// File: tb/wait_state_gen_tb_top.sv
module wait_state_gen_tb_top;
  localparam int CNT_W = 3;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             strobe_i = 1'b0;
  logic             burst_i = 1'b0;
  logic [LEN_W-1:0] burst_len_i = '0;
  logic             rdy_n_i = 1'b1;
  logic             wait_en_i = 1'b0;
  logic [CNT_W-1:0] first_wait_i = '0;
  logic [CNT_W-1:0] later_wait_i = '0;
  logic             zero_wait_burst_i = 1'b0;
  logic             beat_done_o, xfer_done_o, busy_o;
  logic [LEN_W-1:0] beat_idx_o;

  wait_state_gen #(.CNT_W(CNT_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .burst_i(burst_i),
    .burst_len_i(burst_len_i), .rdy_n_i(rdy_n_i), .wait_en_i(wait_en_i),
    .first_wait_i(first_wait_i), .later_wait_i(later_wait_i),
    .zero_wait_burst_i(zero_wait_burst_i), .beat_done_o(beat_done_o),
    .xfer_done_o(xfer_done_o), .beat_idx_o(beat_idx_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    cyc;
    int    idx;
    bit    last;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  int   ext_w[16];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && beat_done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 stray completion", cyc, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc == e.cyc, {e.tag, " beat cycle"}, cyc, e.cyc);
        chk(int'(beat_idx_o) == e.idx, {e.tag, " R7 beat index"}, int'(beat_idx_o), e.idx);
        chk(xfer_done_o == e.last, {e.tag, " R7 final flag"}, int'(xfer_done_o), int'(e.last));
      end
    end
  end

  task automatic scramble(input bit ext, input int dn[16], input int nb);
    strobe_i          = 1'($urandom);
    burst_i           = 1'($urandom);
    burst_len_i       = LEN_W'($urandom);
    wait_en_i         = 1'($urandom);
    first_wait_i      = CNT_W'($urandom);
    later_wait_i      = CNT_W'($urandom);
    zero_wait_burst_i = 1'($urandom);
    if (ext) begin
      rdy_n_i = 1'b1;
      for (int k = 0; k < nb; k++) if (dn[k] == cyc) rdy_n_i = 1'b0;
    end else begin
      rdy_n_i = 1'($urandom);
    end
  endtask

  task automatic run(input bit ext, input bit bu, input int len, input int f,
                     input int n, input bit zw, input string tag);
    int dn[16];
    int nb;
    int t;
    nb = bu ? len + 1 : 1;
    @(posedge clk); #1;
    t = cyc;
    for (int k = 0; k < nb; k++) begin
      if (ext) dn[k] = (k == 0) ? t + ext_w[0] : dn[k-1] + 1 + ext_w[k];
      else if (k == 0) dn[k] = t + f + 1;
      else dn[k] = dn[k-1] + (zw ? 1 : n + 2);
      exp_q.push_back('{cyc: dn[k], idx: k, last: (k == nb - 1), tag: tag});
    end
    strobe_i = 1'b1; burst_i = bu; burst_len_i = LEN_W'(len);
    wait_en_i = !ext; first_wait_i = CNT_W'(f); later_wait_i = CNT_W'(n);
    zero_wait_burst_i = zw;
    rdy_n_i = !(ext && dn[0] == t);
    while (1) begin
      @(posedge clk); #1;
      if (cyc > dn[nb-1]) break;
      scramble(ext, dn, nb);
    end
    strobe_i = 1'b0; rdy_n_i = 1'b1; wait_en_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, {tag, " missing completions"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #2;
    chk(busy_o == 1'b0, "R9 reset busy", int'(busy_o), 0);
    chk(beat_done_o == 1'b0, "R9 reset beat", int'(beat_done_o), 0);
    chk(xfer_done_o == 1'b0, "R9 reset xfer", int'(xfer_done_o), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    rdy_n_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(beat_done_o == 1'b0, "R9 idle ready ignored", int'(beat_done_o), 0);
    end
    @(posedge clk); #1 rdy_n_i = 1'b1;

    run(1'b0, 1'b0, 0, 0, 0, 1'b0, "R2 single first=0");
    run(1'b0, 1'b0, 0, 7, 0, 1'b0, "R2 single first=7");
    run(1'b0, 1'b1, 3, 2, 0, 1'b0, "R3 burst later=0 R5 R6 R8");
    run(1'b0, 1'b1, 3, 4, 5, 1'b0, "R3 burst later=5");
    run(1'b0, 1'b1, 3, 1, 6, 1'b1, "R4 zero-wait burst");
    run(1'b0, 1'b1, 15, 0, 7, 1'b0, "R7 longest burst");
    ext_w[0] = 0;
    run(1'b1, 1'b0, 0, 5, 5, 1'b0, "R1 ext same-cycle ready");
    ext_w[0] = 3;
    run(1'b1, 1'b0, 0, 0, 0, 1'b0, "R1 ext three waits");
    ext_w[0] = 0; ext_w[1] = 0; ext_w[2] = 2; ext_w[3] = 1;
    run(1'b1, 1'b1, 3, 3, 3, 1'b1, "R1 R4 ext burst zero-wait flag ignored");
    ext_w[0] = 1; ext_w[1] = 0;
    run(1'b1, 1'b1, 1, 0, 0, 1'b0, "R7 ext two-beat burst");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule